// File: doc/BRIEF.md
# Serial Slave Front End with Pause Control

This block is the receive and transmit front end of a serial memory slave on a mode-0 SPI bus (clock idles low). The four bus inputs (serial clock, active-low select, data in and an active-low pause line) are brought into a faster system clock domain. Edges are found on the synchronized serial clock. Each completed byte goes to the core with a one-cycle valid strobe. The core supplies the byte to send back, and the block shifts that byte out.

The pause line lets a bus master stop a transfer partway through a byte and resume it later without losing any bits. A pause only takes effect, or ends, while the serial clock is low. If the line changes while the clock is high, the change waits until the clock next falls. If the master drops select while the slave is paused, the partial transfer is discarded. The slave then stays locked out until the pause line has been released while the slave is deselected. A busy flag from a background write or erase engine is carried straight through and is never affected by pausing.

Top module: `spi_hold_slave`

## Requirements
- R1: Data in is sampled on each rising serial clock edge, most significant bit first. After the 8th unpaused rising edge of a byte, rx_byte_o holds the byte and rx_valid_o is high for exactly one system clock.
- R2: miso_o carries tx_byte_i most significant bit first. The first bit is valid before the first rising edge, and each following bit changes on a falling edge. At every byte boundary tx_byte_i is reloaded.
- R3: miso_oe_o is high only while the slave is selected, not paused and not locked out.
- R4: If the pause line falls while selected and while the serial clock is low, paused_o rises within the synchronizer latency.
- R5: If the pause line falls while the serial clock is high, paused_o stays low until the serial clock next goes low.
- R6: If the pause line rises while the serial clock is low, the pause ends at once. If it rises while the serial clock is high, the pause ends only when the serial clock next goes low.
- R7: While paused, serial clock and data-in edges are ignored, and the received bit count and partial byte are kept.
- R8: busy_o follows busy_i whether or not the slave is paused.
- R9: A high select clears the bit count. A partial byte is discarded and gives no strobe.
- R10: If select goes high while paused, the slave is reset and locked. A low select with the pause line still low neither pauses again nor enables the output, and traffic is ignored. Normal operation returns once the pause line is high while select is high.
- R11: With select high, a low pause line does not cause a pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low pause request |
| tx_byte_i | input | 8 | Byte to shift out next |
| busy_i | input | 1 | Busy flag from write/erase engine |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe per received byte |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for serial data out |
| busy_o | output | 1 | Busy flag passed through |
| paused_o | output | 1 | Slave is in the paused state |

## Verification
Bytes are sent in back-to-back frames that change the transmit byte mid-frame, which shows whether the reload happens at the byte boundary. A pause starting with the clock low shows immediate entry and exit. A pause starting with the clock high, and ending with the clock high again, shows that both changes are deferred to clock-low; junk clocks during the pause show whether the partial byte survives. Partial frames ended by deselect, with and without a pause, separate a plain counter clear from the lock-out, and a scoreboard rejects any stray strobe.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_PAUSE = 2'd1,
    HS_LOCK  = 2'd2
  } hold_state_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic cs_n_s_i,
  input  logic hold_n_s_i,
  output logic active_o,
  output logic paused_o,
  output logic locked_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_RUN: begin
        // pause only while selected and clock low
        if (!cs_n_s_i && !hold_n_s_i && !sclk_s_i) state_d = HS_PAUSE;
      end
      HS_PAUSE: begin
        if (cs_n_s_i) state_d = HS_LOCK;
        else if (hold_n_s_i && !sclk_s_i) state_d = HS_RUN;
      end
      HS_LOCK: begin
        // release needs pause line high while deselected
        if (cs_n_s_i && hold_n_s_i) state_d = HS_RUN;
      end
      default: state_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_RUN;
    else state_q <= state_d;
  end

  assign active_o = (state_q == HS_RUN) && !cs_n_s_i;
  assign paused_o = (state_q == HS_PAUSE);
  assign locked_o = (state_q == HS_LOCK);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              miso_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] rx_sh_q, tx_sh_q, rx_byte_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      rx_byte_q <= '0;
      cnt_q     <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (clr_i) begin
        rx_sh_q <= '0;
        cnt_q   <= '0;
        tx_sh_q <= tx_byte_i;
      end else begin
        if (rise_i) begin
          rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_i};
          if (cnt_q == LAST_BIT) begin
            cnt_q     <= '0;
            rx_byte_q <= {rx_sh_q[DATA_W-2:0], mosi_i};
            valid_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (fall_i) begin
          if (cnt_q == '0) tx_sh_q <= tx_byte_i;
          else tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_byte_o  = rx_byte_q;
  assign rx_valid_o = valid_q;
  assign miso_o     = tx_sh_q[DATA_W-1];
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  input  logic          hold_ni,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          busy_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          busy_o,
  output logic          paused_o
);
  localparam int unsigned CNT_W = $clog2(DW);

  logic [3:0] raw, synced;
  logic sclk_s, cs_n_s, mosi_s, hold_n_s, sclk_q;
  logic active, locked, rise, fall, clr;
  logic [CNT_W-1:0] bit_cnt;

  assign raw = {hold_ni, mosi_i, cs_ni, sclk_i};

  spi_in_sync #(.WIDTH(4), .STAGES(STAGES), .RST_VAL(4'b1010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {hold_n_s, mosi_s, cs_n_s, sclk_s} = synced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else sclk_q <= sclk_s;
  end

  spi_hold_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sclk_s),
    .cs_n_s_i  (cs_n_s),
    .hold_n_s_i(hold_n_s),
    .active_o  (active),
    .paused_o  (paused_o),
    .locked_o  (locked)
  );

  assign rise = active && sclk_s && !sclk_q;
  assign fall = active && !sclk_s && sclk_q;
  assign clr  = cs_n_s || locked;

  spi_shift #(.DATA_W(DW)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .rise_i    (rise),
    .fall_i    (fall),
    .mosi_i    (mosi_s),
    .tx_byte_i (tx_byte_i),
    .rx_byte_o (rx_byte_o),
    .rx_valid_o(rx_valid_o),
    .miso_o    (miso_o),
    .bit_cnt_o (bit_cnt)
  );

  assign miso_oe_o = active;
  assign busy_o    = busy_i;
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             paused_o,
  input logic             miso_oe_o,
  input logic             rx_valid_o,
  input logic             sclk_s,
  input logic             cs_n_s,
  input logic             locked,
  input logic [CNT_W-1:0] bit_cnt
);
  // R1
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R3
  oe_off_paused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o || locked) |-> !miso_oe_o);

  // R5
  pause_entry_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> !$past(sclk_s));

  // R6
  pause_exit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(paused_o) |-> (!$past(sclk_s) || locked));

  // R7
  cnt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && $past(paused_o)) |-> $stable(bit_cnt));

  // R11
  pause_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> !$past(cs_n_s));
endmodule

bind spi_hold_slave spi_hold_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .paused_o  (paused_o),
  .miso_oe_o (miso_oe_o),
  .rx_valid_o(rx_valid_o),
  .sclk_s    (sclk_s),
  .cs_n_s    (cs_n_s),
  .locked    (locked),
  .bit_cnt   (bit_cnt)
);

// File: tb/test_spi_hold_slave.sv
module test_spi_hold_slave;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic rx_valid, miso, miso_oe, busy_o, paused;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  spi_hold_slave i_spi_hold_slave (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk),
    .cs_ni     (cs_n),
    .mosi_i    (mosi),
    .hold_ni   (hold_n),
    .tx_byte_i (tx_byte),
    .busy_i    (busy),
    .rx_byte_o (rx_byte),
    .rx_valid_o(rx_valid),
    .miso_o    (miso),
    .miso_oe_o (miso_oe),
    .busy_o    (busy_o),
    .paused_o  (paused)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R10", "unexpected byte strobe", rx_byte, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_byte == e, "R1", "received byte", rx_byte, e);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic so);
    mosi = b;
    wclk(8);
    so = miso;
    sclk = 1'b1;
    wclk(8);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit do_tx, input logic [7:0] exp_tx);
    logic [7:0] got;
    logic so;
    exp_q.push_back(d);
    for (int i = 7; i >= 0; i--) begin
      send_bit(d[i], so);
      got[i] = so;
    end
    if (do_tx) chk(got == exp_tx, "R2", "transmitted byte", got, exp_tx);
  endtask

  task automatic junk_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = ~mosi;
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
      wclk(4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic so;
    logic [7:0] d;
    wclk(3);
    chk(!rx_valid && !paused && !miso_oe, "R3", "reset outputs", {rx_valid, paused, miso_oe}, 0);
    rst_ni = 1'b1;
    wclk(6);
    chk(!rx_valid && !paused && !miso_oe, "R3", "idle after reset", {rx_valid, paused, miso_oe}, 0);

    // two-byte frame, tx byte reloaded at boundary
    tx_byte = 8'hA5;
    wclk(4);
    cs_n = 1'b0;
    wclk(8);
    chk(miso_oe == 1'b1, "R3", "oe when selected", miso_oe, 1);
    tx_byte = 8'h3C;
    send_byte(8'h69, 1'b1, 8'hA5);
    send_byte(8'hF0, 1'b1, 8'h3C);
    wclk(8);
    cs_n = 1'b1;
    wclk(8);
    chk(miso_oe == 1'b0, "R3", "oe when deselected", miso_oe, 0);

    // R11: pause line low while deselected
    hold_n = 1'b0;
    wclk(8);
    chk(paused == 1'b0, "R11", "no pause when deselected", paused, 0);
    hold_n = 1'b1;
    wclk(8);

    // R4/R7/R8: pause with clock low, mid-byte
    d = 8'hC3;
    cs_n = 1'b0;
    wclk(8);
    exp_q.push_back(d);
    for (int i = 7; i >= 4; i--) send_bit(d[i], so);
    hold_n = 1'b0;
    busy = 1'b1;
    wclk(6);
    chk(paused == 1'b1, "R4", "pause entered with clock low", paused, 1);
    chk(miso_oe == 1'b0, "R3", "oe off while paused", miso_oe, 0);
    chk(busy_o == 1'b1, "R8", "busy during pause", busy_o, 1);
    junk_clocks(3);
    hold_n = 1'b1;
    wclk(6);
    chk(paused == 1'b0, "R6", "pause left with clock low", paused, 0);
    chk(miso_oe == 1'b1, "R3", "oe back after pause", miso_oe, 1);
    busy = 1'b0;
    wclk(4);
    chk(busy_o == 1'b0, "R8", "busy cleared", busy_o, 0);
    for (int i = 3; i >= 0; i--) send_bit(d[i], so); // R7 checked by scoreboard
    wclk(8);

    // R5/R6: pause changes while clock high are deferred
    d = 8'h5A;
    exp_q.push_back(d);
    for (int i = 7; i >= 5; i--) send_bit(d[i], so);
    mosi = d[4];
    wclk(8);
    sclk = 1'b1;
    wclk(4);
    hold_n = 1'b0;
    wclk(6);
    chk(paused == 1'b0, "R5", "no pause while clock high", paused, 0);
    sclk = 1'b0;
    wclk(6);
    chk(paused == 1'b1, "R5", "pause at clock low", paused, 1);
    junk_clocks(2);
    sclk = 1'b1;
    wclk(4);
    hold_n = 1'b1;
    wclk(6);
    chk(paused == 1'b1, "R6", "still paused while clock high", paused, 1);
    sclk = 1'b0;
    wclk(6);
    chk(paused == 1'b0, "R6", "resume at clock low", paused, 0);
    for (int i = 3; i >= 0; i--) send_bit(d[i], so);
    wclk(8);
    cs_n = 1'b1;
    wclk(8);

    // R9: partial byte discarded
    cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < 5; i++) send_bit(1'b1, so);
    wclk(4);
    cs_n = 1'b1;
    wclk(8);
    cs_n = 1'b0;
    wclk(8);
    send_byte(8'h81, 1'b0, 8'h00);
    wclk(8);
    cs_n = 1'b1;
    wclk(8);

    // R10: deselect while paused locks out
    tx_byte = 8'hE7;
    cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < 3; i++) send_bit(1'b0, so);
    hold_n = 1'b0;
    wclk(6);
    chk(paused == 1'b1, "R10", "paused before deselect", paused, 1);
    cs_n = 1'b1;
    wclk(6);
    chk(paused == 1'b0, "R10", "deselect ends pause", paused, 0);
    cs_n = 1'b0;
    wclk(6);
    chk(paused == 1'b0, "R10", "no re-pause while locked", paused, 0);
    chk(miso_oe == 1'b0, "R10", "oe off while locked", miso_oe, 0);
    for (int i = 0; i < 8; i++) send_bit(1'b1, so);
    wclk(4);
    cs_n = 1'b1;
    hold_n = 1'b1;
    wclk(8);
    cs_n = 1'b0;
    wclk(8);
    chk(miso_oe == 1'b1, "R10", "oe after unlock", miso_oe, 1);
    send_byte(8'h96, 1'b1, 8'hE7);
    wclk(8);
    cs_n = 1'b1;
    wclk(20);
    chk(exp_q.size() == 0, "R1", "all expected bytes received", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule